// File: doc/BRIEF.md
# Paged Memory Address Counter and Write-Cycle Controller

This block keeps the byte address pointer of a 256-location, byte-wide memory arranged as 16 pages of 16 bytes. A serial protocol engine in front of it signals four events: an address byte was received, a data byte was received, a data byte was read out, and the transfer ended. The block moves its pointer under two wrap rules. Reads walk the whole memory and wrap from the last location to the first. Writes move only within the current page.

Written bytes are not stored in the array at once. They collect in a 16-entry page buffer, and each entry has its own valid flag. When the transfer ends, the flagged entries are copied into the array and a timed internal write cycle begins. A busy flag is high for the length of that cycle, and every strobe is ignored while it is high. A transfer that carried only an address byte moves the pointer and nothing else. It is used to set up a read at a chosen location.

Top module: `eeprom_addr_ctrl`

## Requirements
- R1: After reset, `cur_addr` is 0, `busy` is 0 and every memory location reads 0.
- R2: A `rd_adv` strobe advances `cur_addr` by one across the full 8-bit range, wrapping from 255 to 0. `rd_data` shows the byte at `cur_addr` during the strobe cycle.
- R3: A `wr_byte` strobe buffers `wr_data` for location `cur_addr`. It then increments only `cur_addr[3:0]`, which wraps from 15 to 0 while `cur_addr[7:4]` is kept. For example, two bytes written from address 31 land at 31 and then 16, and the pointer ends at 17.
- R4: When more than 16 bytes are written in one transfer, each location of the page holds the last byte written to it.
- R5: A `load_addr` strobe sets `cur_addr` to `addr_in`. If a transfer holds only an address and then ends with `stop`, no memory location changes and `busy` stays 0.
- R6: A `stop` after at least one buffered byte copies only the buffered locations into the array. The other locations of the page keep their contents.
- R7: `busy` rises in the cycle after such a `stop` and stays high for exactly `WR_CYCLES` clock cycles.
- R8: While `busy` is high, `load_addr`, `wr_byte`, `rd_adv` and `stop` have no effect on `cur_addr` or on the memory contents.
- R9: When several strobes are high in the same cycle, only the one with the highest priority acts. The order is `load_addr`, then `wr_byte`, then `rd_adv`, then `stop`.
- R10: With no strobe active, `cur_addr` holds its value, including across the end of a transfer and the write cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_addr | input | 1 | Address byte received; load pointer from `addr_in` |
| addr_in | input | 8 | Address value to load |
| wr_byte | input | 1 | Data byte received for writing |
| wr_data | input | 8 | Byte to buffer |
| rd_adv | input | 1 | Byte read out; advance pointer |
| stop | input | 1 | End of transfer |
| cur_addr | output | 8 | Current address pointer |
| rd_data | output | 8 | Memory byte at `cur_addr` |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The assertions check on every cycle how the pointer moves for each strobe. They cover the full-range read increment, the in-page write increment, the address load, holding the value when idle, and freezing it while busy. A counter of consecutive busy cycles checks the exact length of the write cycle. Only the bench's scenarios can show where bytes end up in memory. These include page wrap-around at address 31, overwriting in a transfer longer than a page, copying only the buffered locations, a dummy write that leaves memory untouched, and writes ignored during busy. Each of these is seen through later reads.

// File: rtl/eeprom_addr_ctrl.sv
module eeprom_addr_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_byte,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_adv,
  input  logic              stop,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);

  logic [DATA_W-1:0]        mem     [DEPTH];
  logic [DATA_W-1:0]        pg_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]    pg_vld;
  logic [ADDR_W-PAGE_W-1:0] pg_sel;
  logic [CNT_W-1:0]         cyc_cnt;

  wire idle    = ~busy;
  wire do_load = idle & load_addr;
  wire do_wr   = idle & ~load_addr & wr_byte;
  wire do_rd   = idle & ~load_addr & ~wr_byte & rd_adv;
  wire do_stop = idle & ~load_addr & ~wr_byte & ~rd_adv & stop;
  wire commit  = do_stop & (|pg_vld);

  assign busy    = (cyc_cnt != '0);
  assign rd_data = mem[cur_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_addr <= '0;
    else if (do_load) cur_addr <= addr_in;
    else if (do_wr)   cur_addr <= {cur_addr[ADDR_W-1:PAGE_W], cur_addr[PAGE_W-1:0] + 1'b1};
    else if (do_rd)   cur_addr <= cur_addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_vld <= '0;
      pg_sel <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pg_data[i] <= '0;
    end else if (do_wr) begin
      pg_data[cur_addr[PAGE_W-1:0]] <= wr_data;
      pg_vld[cur_addr[PAGE_W-1:0]]  <= 1'b1;
      pg_sel <= cur_addr[ADDR_W-1:PAGE_W];
    end else if (do_stop) begin
      pg_vld <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (pg_vld[j]) mem[{pg_sel, PAGE_W'(j)}] <= pg_data[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_cnt <= '0;
    else if (commit) cyc_cnt <= CNT_W'(WR_CYCLES);
    else if (busy)   cyc_cnt <= cyc_cnt - 1'b1;
  end
endmodule

// File: rtl/eeprom_addr_ctrl_chk.sv
module eeprom_addr_ctrl_chk #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_addr,
  input logic [ADDR_W-1:0] addr_in,
  input logic              wr_byte,
  input logic              rd_adv,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              busy
);
  int busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  AST_RD_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && !wr_byte && !load_addr && !busy) |=> cur_addr == ADDR_W'($past(cur_addr) + 1)); // R2
  AST_WR_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte && !load_addr && !busy) |=> (cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W]))
      && (cur_addr[PAGE_W-1:0] == PAGE_W'($past(cur_addr[PAGE_W-1:0]) + 1))); // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_addr && !busy) |=> cur_addr == $past(addr_in)); // R9
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_addr && !wr_byte && !rd_adv) |=> $stable(cur_addr)); // R10
  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_run < WR_CYCLES); // R7
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == WR_CYCLES); // R7
endmodule

bind eeprom_addr_ctrl eeprom_addr_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .addr_in(addr_in),
  .wr_byte(wr_byte), .rd_adv(rd_adv), .cur_addr(cur_addr), .busy(busy)
);

// File: tb/eeprom_addr_ctrl_bench.sv
module eeprom_addr_ctrl_bench;
  localparam int W = 20;
  logic clk = 0, rst_n = 0;
  logic load_addr = 0, wr_byte = 0, rd_adv = 0, stop = 0;
  logic [7:0] addr_in = 0, wr_data = 0;
  logic [7:0] cur_addr, rd_data;
  logic busy;

  eeprom_addr_ctrl #(.WR_CYCLES(W)) u_eeprom_addr_ctrl (
    .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .addr_in(addr_in),
    .wr_byte(wr_byte), .wr_data(wr_data), .rd_adv(rd_adv), .stop(stop),
    .cur_addr(cur_addr), .rd_data(rd_data), .busy(busy));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] mm [256];
  logic [7:0] pb [16];
  logic [15:0] pv;
  logic [3:0] ppg;
  logic [7:0] mptr;
  logic [15:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_adv && !busy && !load_addr && !wr_byte) begin
      if (exp_q.size() == 0) chk("R2 unexpected read", 1, 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " addr"}, cur_addr, e[15:8]);
        chk({t, " data"}, rd_data, e[7:0]);
      end
    end
  end

  task automatic load(input logic [7:0] a);
    @(posedge clk); #1 load_addr = 1; addr_in = a;
    @(posedge clk); #1 load_addr = 0;
    mptr = a;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1 wr_byte = 1; wr_data = d;
    @(posedge clk); #1 wr_byte = 0;
    pb[mptr[3:0]] = d; pv[mptr[3:0]] = 1'b1; ppg = mptr[7:4];
    mptr = {mptr[7:4], mptr[3:0] + 4'd1};
  endtask

  task automatic rd(input string t);
    @(posedge clk); #1 rd_adv = 1;
    exp_q.push_back({mptr, mm[mptr]}); tag_q.push_back(t);
    @(posedge clk); #1 rd_adv = 0;
    mptr = mptr + 8'd1;
  endtask

  task automatic end_xfer();
    int n;
    logic had;
    had = |pv;
    @(posedge clk); #1 stop = 1;
    @(posedge clk); #1 stop = 0;
    for (int j = 0; j < 16; j++) if (pv[j]) mm[{ppg, 4'(j)}] = pb[j];
    pv = '0;
    n = 0;
    for (int k = 0; k < W + 5; k++) begin
      @(negedge clk);
      if (busy) n++;
    end
    chk(had ? "R7 busy length" : "R5 no write cycle", n, had ? W : 0);
  endtask

  initial begin
    #400000;
    chk("watchdog", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mm[i] = 8'h00;
    pv = '0; ppg = 0; mptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset addr", cur_addr, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset data", rd_data, 0);
    #1 rst_n = 1;

    load(8'd31); wr(8'hA1); wr(8'hB2);
    @(negedge clk); chk("R3 page wrap pointer", cur_addr, 17);
    end_xfer();
    @(negedge clk); chk("R10 pointer kept", cur_addr, 17);
    load(8'd16); rd("R3 wrapped byte"); rd("R6 untouched");
    load(8'd30); rd("R6 untouched"); rd("R3 first byte");
    load(8'd254); rd("R2 read"); rd("R2 read"); rd("R2 wrap to 0");
    @(negedge clk); chk("R2 pointer after wrap", cur_addr, 1);

    load(8'h40);
    for (int i = 0; i < 18; i++) wr(8'h10 + 8'(i));
    end_xfer();
    load(8'h40);
    for (int i = 0; i < 16; i++) rd("R4 overwrite");

    load(8'h55); end_xfer();
    @(negedge clk); chk("R5 dummy write pointer", cur_addr, 8'h55);
    rd("R5 memory unchanged");

    load(8'h80); wr(8'h5C);
    @(posedge clk); #1 stop = 1;
    @(posedge clk); #1 stop = 0;
    mm[8'h80] = 8'h5C; pv = '0;
    @(negedge clk); chk("R7 busy after stop", busy, 1);
    #1 wr_byte = 1; wr_data = 8'hEE; load_addr = 1; addr_in = 8'h00; rd_adv = 1; stop = 1;
    @(posedge clk); #1 wr_byte = 0; load_addr = 0; rd_adv = 0; stop = 0;
    @(negedge clk); chk("R8 pointer frozen", cur_addr, 8'h81);
    chk("R8 still busy", busy, 1);
    while (busy) @(negedge clk);
    mptr = 8'h81;
    chk("R8 pointer after busy", cur_addr, 8'h81);
    rd("R8 no write while busy");
    load(8'h80); rd("R6 committed byte");

    @(posedge clk); #1 load_addr = 1; addr_in = 8'hC3; wr_byte = 1; wr_data = 8'h77; rd_adv = 1;
    @(posedge clk); #1 load_addr = 0; wr_byte = 0; rd_adv = 0;
    mptr = 8'hC3;
    @(negedge clk); chk("R9 load wins", cur_addr, 8'hC3);
    end_xfer();
    rd("R9 write dropped");

    repeat (3) @(negedge clk);
    chk("R2 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule